// File: doc/BRIEF.md
# Bus Cycle Termination Resolver

This block sits beside the bus master of a processor and decides how each bus cycle ends. The master opens a cycle with a start strobe, which also tells the block whether the cycle is a read and whether it is an interrupt acknowledge. From then on, the block samples the slave's termination inputs on every clock edge. These inputs are a synchronous terminate, a two-bit asynchronous acknowledge code, a bus-error line, a halt line and an autovector line.

When one of the samples amounts to a valid termination, the block reduces the inputs present to a single outcome. Conflicts are settled by a fixed priority: retry first, then bus error, then autovector, then synchronous terminate, then asynchronous acknowledge. The block then reports the outcome for exactly one cycle, together with the width of the responding port and a data-capture enable for reads. If no valid termination arrives within a parameterised number of sampling edges, the block ends the cycle with a bus error itself.

The control is a three-state machine:
- **IDLE** moves to **ACTIVE** when `cyc_start` is high. This transition is called *open*.
- **ACTIVE** moves to **REPORT** on a resolved termination (*terminate*) or on timeout expiry (*expire*). Otherwise it stays in ACTIVE and adds a wait state (*wait*).
- **REPORT** always returns to **IDLE** (*close*).

Top module: `bus_term_resolver`

## Requirements
- R1: After reset, `done` and `latch_data` are 0 and `outcome` and `port_width` are 0, and the block is idle.
- R2: A cycle opens only from idle, on an edge where `cyc_start` is 1, and `cyc_is_read`/`cyc_is_iack` are captured at that edge. A `cyc_start` seen while a cycle is open or being reported is ignored.
- R3: `done` is high for exactly one cycle, in the cycle after the terminating edge. `outcome`, `port_width` and `latch_data` are 0 whenever `done` is 0.
- R4: A sampled `sync_term` ends the cycle with outcome 1 (normal) and `port_width` 3 (32-bit).
- R5: `async_ack` codes are: 00 = keep waiting, 01 = normal with width 3 (32-bit), 10 = normal with width 2 (16-bit), 11 = normal with width 1 (8-bit).
- R6: `berr` without `halt` gives outcome 2 (bus error) and width 0. This holds whether it arrives alone or together with a synchronous or asynchronous acknowledge, and also in an interrupt acknowledge cycle with `autovec`.
- R7: `berr` together with `halt` gives outcome 3 (retry) and width 0, with or without an acknowledge. `halt` alone does not end a cycle.
- R8: In an interrupt acknowledge cycle, `autovec` gives outcome 4 (autovector) with width 0 and takes precedence over both acknowledges. In any other cycle `autovec` has no effect.
- R9: When `sync_term` and a non-zero `async_ack` arrive together, the width is 3 (32-bit), whatever the code says.
- R10: `latch_data` rises with `done` only for a normal outcome in a read cycle.
- R11: If `TIMEOUT_CYCLES` consecutive sampling edges in a cycle carry no valid termination, the cycle ends with outcome 2. A valid termination on the last of those edges is reported as that termination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Opens a bus cycle when idle |
| cyc_is_read | input | 1 | Cycle is a read (captured at open) |
| cyc_is_iack | input | 1 | Cycle is an interrupt acknowledge (captured at open) |
| sync_term | input | 1 | Synchronous terminate, 32-bit port |
| async_ack | input | 2 | Asynchronous acknowledge / port width code |
| berr | input | 1 | Bus error |
| halt | input | 1 | Halt; with `berr` requests retry |
| autovec | input | 1 | Autovector request |
| done | output | 1 | One-cycle completion pulse |
| outcome | output | 3 | 0 none, 1 normal, 2 bus error, 3 retry, 4 autovector |
| port_width | output | 2 | 0 none, 1 8-bit, 2 16-bit, 3 32-bit |
| latch_data | output | 1 | Capture read data this cycle |

## Verification
Wait-state timeout expiry and a genuine slave termination can fall on the same sampling edge. The bench provokes this by holding the termination inputs idle for exactly `TIMEOUT_CYCLES - 1` edges. On the next edge it either applies nothing, in which case a bus error is expected, or applies a synchronous terminate, in which case a normal 32-bit completion is expected. The bench also checks that `done` stays low through every preceding wait edge. A second class of coincidence is several termination inputs in one sample, such as bus error with an acknowledge, or autovector with a synchronous terminate. The bench judges each of these against the fixed priority order.

// File: rtl/btr_pkg.sv
package btr_pkg;

    typedef enum logic [2:0] {
        OUT_NONE    = 3'd0,
        OUT_NORMAL  = 3'd1,
        OUT_BUSERR  = 3'd2,
        OUT_RETRY   = 3'd3,
        OUT_AUTOVEC = 3'd4
    } outcome_e;

    typedef enum logic [1:0] {
        PW_NONE = 2'd0,
        PW_8    = 2'd1,
        PW_16   = 2'd2,
        PW_32   = 2'd3
    } pwidth_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_REPORT = 2'd2
    } btr_state_e;

    typedef struct packed {
        outcome_e outcome;
        pwidth_e  width;
        logic     latch;
    } term_result_t;

    localparam term_result_t RESULT_IDLE = '{OUT_NONE, PW_NONE, 1'b0};

endpackage

// File: rtl/btr_resolve.sv
module btr_resolve
    import btr_pkg::*;
(
    input  logic         sync_term,
    input  logic [1:0]   async_ack,
    input  logic         berr,
    input  logic         halt,
    input  logic         autovec,
    input  logic         is_iack,
    input  logic         is_read,
    output logic         res_valid,
    output term_result_t res
);

    pwidth_e ack_width;

    // Width decoded from the asynchronous acknowledge code
    always_comb begin
        unique case (async_ack)
            2'b01:   ack_width = PW_32;
            2'b10:   ack_width = PW_16;
            2'b11:   ack_width = PW_8;
            default: ack_width = PW_NONE;
        endcase
    end

    // Fixed priority: retry, error, autovector, synchronous, asynchronous
    always_comb begin
        res_valid   = 1'b1;
        res.outcome = OUT_NONE;
        res.width   = PW_NONE;
        if (berr && halt) begin
            res.outcome = OUT_RETRY;
        end else if (berr) begin
            res.outcome = OUT_BUSERR;
        end else if (autovec && is_iack) begin
            res.outcome = OUT_AUTOVEC;
        end else if (sync_term) begin
            res.outcome = OUT_NORMAL;
            res.width   = PW_32;
        end else if (async_ack != 2'b00) begin
            res.outcome = OUT_NORMAL;
            res.width   = ack_width;
        end else begin
            res_valid   = 1'b0;
        end
        res.latch = res_valid && (res.outcome == OUT_NORMAL) && is_read;
    end

endmodule

// File: rtl/btr_wait_timer.sv
module btr_wait_timer #(
    parameter int unsigned TIMEOUT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic expired
);

    localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = step && (cnt_q == LAST);

endmodule

// File: rtl/bus_term_resolver.sv
module bus_term_resolver
    import btr_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  logic       cyc_is_read,
    input  logic       cyc_is_iack,
    input  logic       sync_term,
    input  logic [1:0] async_ack,
    input  logic       berr,
    input  logic       halt,
    input  logic       autovec,
    output logic       done,
    output logic [2:0] outcome,
    output logic [1:0] port_width,
    output logic       latch_data
);

    btr_state_e   state_q, state_d;
    term_result_t result_q;
    term_result_t res;
    logic         res_valid;
    logic         read_q, iack_q;
    logic         active, expired;

    assign active = (state_q == ST_ACTIVE);

    btr_resolve u_resolve (
        .sync_term (sync_term),
        .async_ack (async_ack),
        .berr      (berr),
        .halt      (halt),
        .autovec   (autovec),
        .is_iack   (iack_q),
        .is_read   (read_q),
        .res_valid (res_valid),
        .res       (res)
    );

    btr_wait_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!active),
        .step    (active && !res_valid),
        .expired (expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cyc_start) state_d = ST_ACTIVE;
            ST_ACTIVE: if (res_valid || expired) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Cycle attributes and resolved result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            read_q   <= 1'b0;
            iack_q   <= 1'b0;
            result_q <= RESULT_IDLE;
        end else begin
            if (state_q == ST_IDLE && cyc_start) begin
                read_q <= cyc_is_read;
                iack_q <= cyc_is_iack;
            end
            if (active) begin
                if (res_valid)    result_q <= res;
                else if (expired) result_q <= '{OUT_BUSERR, PW_NONE, 1'b0};
            end
        end
    end

    // Outputs
    always_comb begin
        done       = 1'b0;
        outcome    = OUT_NONE;
        port_width = PW_NONE;
        latch_data = 1'b0;
        unique case (state_q)
            ST_REPORT: begin
                done       = 1'b1;
                outcome    = result_q.outcome;
                port_width = result_q.width;
                latch_data = result_q.latch;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/btr_checker.sv
module btr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_term,
    input logic [1:0] async_ack,
    input logic       berr,
    input logic       halt,
    input logic       done,
    input logic [2:0] outcome,
    input logic [1:0] port_width,
    input logic       latch_data
);

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_quiet_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (outcome == 3'd0 && port_width == 2'd0 && !latch_data));

    p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(berr && halt)) |-> outcome == 3'd3);

    p_buserr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(berr && !halt)) |-> (outcome == 3'd2 && port_width == 2'd0));

    p_sync_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && outcome == 3'd1 && $past(sync_term)) |-> port_width == 2'd3);

    p_half_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && outcome == 3'd1 && !$past(sync_term) && $past(async_ack) == 2'b10)
        |-> port_width == 2'd2);

    p_latch_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        latch_data |-> (done && outcome == 3'd1 && port_width != 2'd0));

endmodule

bind bus_term_resolver btr_checker u_btr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_term  (sync_term),
    .async_ack  (async_ack),
    .berr       (berr),
    .halt       (halt),
    .done       (done),
    .outcome    (outcome),
    .port_width (port_width),
    .latch_data (latch_data)
);

// File: tb/bus_term_resolver_tb.sv
module bus_term_resolver_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0, cyc_is_read = 1'b0, cyc_is_iack = 1'b0;
    logic       sync_term = 1'b0, berr = 1'b0, halt = 1'b0, autovec = 1'b0;
    logic [1:0] async_ack = 2'b00;
    logic       done, latch_data;
    logic [2:0] outcome;
    logic [1:0] port_width;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_term_resolver #(.TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
        .cyc_is_read(cyc_is_read), .cyc_is_iack(cyc_is_iack),
        .sync_term(sync_term), .async_ack(async_ack), .berr(berr),
        .halt(halt), .autovec(autovec), .done(done), .outcome(outcome),
        .port_width(port_width), .latch_data(latch_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        sync_term = 0; async_ack = 2'b00; berr = 0; halt = 0; autovec = 0;
    endtask

    // Opens a cycle, waits, applies one termination sample, checks the report.
    // Cycle flags are inverted after the opening edge to exercise capture (R2).
    task automatic run_cycle(input bit rd, input bit iack, input int waits,
                             input bit nh, input bit nav,
                             input bit st, input logic [1:0] ack, input bit be,
                             input bit hl, input bit av,
                             input int eo, input int ew, input int el,
                             input string tag);
        @(negedge clk);
        cyc_start = 1; cyc_is_read = rd; cyc_is_iack = iack;
        @(negedge clk);
        cyc_start = 0; cyc_is_read = !rd; cyc_is_iack = !iack;
        for (int i = 0; i < waits; i++) begin
            halt = nh; autovec = nav;
            @(negedge clk);
            chk({tag, " wait done (R3/R7/R8/R11)"}, done, 0);
        end
        sync_term = st; async_ack = ack; berr = be; halt = hl; autovec = av;
        @(negedge clk);
        chk({tag, " done"}, done, 1);
        chk({tag, " outcome"}, outcome, eo);
        chk({tag, " width"}, port_width, ew);
        chk({tag, " latch R10"}, latch_data, el);
        clear_inputs();
        @(negedge clk);
        chk({tag, " pulse end R3"}, done, 0);
        chk({tag, " quiet outcome R3"}, outcome, 0);
    endtask

    task automatic t_reset();
        chk("R1 done", done, 0);
        chk("R1 outcome", outcome, 0);
        chk("R1 width", port_width, 0);
        chk("R1 latch", latch_data, 0);
    endtask

    task automatic t_sync();
        run_cycle(1, 0, 0, 0, 0, 1, 2'b00, 0, 0, 0, 1, 3, 1, "R4 sync read");
        run_cycle(0, 0, 2, 0, 0, 1, 2'b00, 0, 0, 0, 1, 3, 0, "R4 sync write");
    endtask

    task automatic t_async();
        run_cycle(1, 0, 1, 0, 0, 0, 2'b01, 0, 0, 0, 1, 3, 1, "R5 ack32");
        run_cycle(1, 0, 3, 0, 0, 0, 2'b10, 0, 0, 0, 1, 2, 1, "R5 ack16");
        run_cycle(0, 0, 0, 0, 0, 0, 2'b11, 0, 0, 0, 1, 1, 0, "R5 ack8");
    endtask

    task automatic t_error();
        run_cycle(0, 0, 1, 0, 0, 0, 2'b00, 1, 0, 0, 2, 0, 0, "R6 berr alone");
        run_cycle(1, 0, 0, 0, 0, 1, 2'b00, 1, 0, 0, 2, 0, 0, "R6 berr+sync");
        run_cycle(1, 0, 0, 0, 0, 0, 2'b11, 1, 0, 0, 2, 0, 0, "R6 berr+async");
        run_cycle(1, 1, 0, 0, 0, 0, 2'b00, 1, 0, 1, 2, 0, 0, "R6 berr+autovec");
    endtask

    task automatic t_retry();
        run_cycle(1, 0, 0, 0, 0, 0, 2'b00, 1, 1, 0, 3, 0, 0, "R7 retry");
        run_cycle(1, 0, 1, 0, 0, 0, 2'b01, 1, 1, 0, 3, 0, 0, "R7 retry+ack");
        run_cycle(1, 0, 3, 1, 0, 0, 2'b10, 0, 1, 0, 1, 2, 1, "R7 halt alone");
    endtask

    task automatic t_autovec();
        run_cycle(0, 1, 1, 0, 0, 0, 2'b00, 0, 0, 1, 4, 0, 0, "R8 autovec");
        run_cycle(1, 1, 0, 0, 0, 1, 2'b11, 0, 0, 1, 4, 0, 0, "R8 autovec over acks");
        run_cycle(1, 0, 3, 0, 1, 0, 2'b10, 0, 0, 1, 1, 2, 1, "R8 autovec ignored");
    endtask

    task automatic t_sync_over_async();
        run_cycle(1, 0, 0, 0, 0, 1, 2'b11, 0, 0, 0, 1, 3, 1, "R9 sync beats ack8");
    endtask

    task automatic t_timeout();
        run_cycle(1, 0, TMO-1, 0, 0, 0, 2'b00, 0, 0, 0, 2, 0, 0, "R11 expiry");
        run_cycle(1, 0, TMO-1, 0, 0, 1, 2'b00, 0, 0, 0, 1, 3, 1, "R11 last edge");
    endtask

    task automatic t_start_ignored();
        @(negedge clk);
        cyc_start = 1; cyc_is_read = 1; cyc_is_iack = 0;
        @(negedge clk);
        cyc_start = 0;
        sync_term = 1;
        @(negedge clk);
        chk("R2 first cycle done", done, 1);
        sync_term = 0;
        cyc_start = 1;             // arrives during report: ignored
        @(negedge clk);
        cyc_start = 0;
        sync_term = 1;             // block idle, must not report
        @(negedge clk);
        chk("R2 start in report ignored", done, 0);
        clear_inputs();
        @(negedge clk);
        chk("R2 still idle", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sync();
        t_async();
        t_error();
        t_retry();
        t_autovec();
        t_sync_over_async();
        t_timeout();
        t_start_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule